// File: doc/BRIEF.md
# SECDED-Protected Data Buffer with Error Injection

This block is a small word-addressed buffer in which every stored word carries Hamming check bits plus one overall parity bit. The check bits are generated on each write. On each read the stored word is decoded: a single flipped bit is repaired before the data leaves the block, and two flipped bits are reported as uncorrectable. Protection can be switched off. When it is off the raw stored data comes back unchanged and no error is ever reported.

To test the error paths without a faulty memory, a small control register can corrupt the codeword as it is written. It can flip nothing, one data bit, one check bit, or two data bits. Corrected and uncorrectable read events each latch a sticky status bit. A mask register decides which of the two status bits raise the interrupt line. Software clears a status bit by writing a 1 to it. The control, status and mask registers sit on a plain write/read strobe bus, and the address decode above that bus belongs to the surrounding logic.

Top module: `ecc_buf`

## Requirements
- R1: After reset, `rd_valid` and `irq` are low, the control register (address 0) reads 1 (protection on, no injection), and the status (address 1) and mask (address 2) registers read 0.
- R2: With protection on and no injection, a word read back equals the word written, and both `rd_sbe` and `rd_dbe` stay low.
- R3: Control bits [2:1] = 01 flip data bit 0 of the word being written. With protection on, a later read returns the original data with `rd_sbe` = 1 and `rd_dbe` = 0.
- R4: Control bits [2:1] = 10 flip check bit 0 of the word being written. The read returns the original data with `rd_sbe` = 1.
- R5: Control bits [2:1] = 11 flip data bits 0 and 1 of the word being written. The read returns the stored data uncorrected (written value XOR 3) with `rd_dbe` = 1 and `rd_sbe` = 0. The two flags are never high together.
- R6: A read flagged single-bit sets status bit 0, and a read flagged double-bit sets status bit 1. A set bit stays set through later clean reads.
- R7: Writing the status register clears exactly the bits written as 1 and leaves the others unchanged.
- R8: `irq` is high exactly when some status bit is set and its matching mask bit (mask bit 0 for single-bit, mask bit 1 for double-bit) is 1.
- R9: With control bit 0 = 0, reads return the stored data without correction, even if injected errors are present, and set no flag or status bit. A word that was corrupted while protection was off is corrected once protection is turned back on.
- R10: `rd_valid` goes high in the cycle after a cycle with `rd_en` and lasts one cycle for each read strobe. A register read returns its value on `csr_rdata` in the cycle after `csr_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | AW | Buffer write address |
| wr_data | input | DW | Buffer write data |
| rd_en | input | 1 | Buffer read strobe |
| rd_addr | input | AW | Buffer read address |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | DW | Read data, corrected when possible |
| rd_sbe | output | 1 | Current read had a corrected single-bit error |
| rd_dbe | output | 1 | Current read had an uncorrectable double-bit error |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_addr | input | 2 | Register select: 0 control, 1 status, 2 mask |
| csr_wdata | input | 3 | Register write data |
| csr_rdata | output | 3 | Register read data, one cycle after `csr_rd` |
| irq | output | 1 | Interrupt: OR of masked status bits |

## Verification
Clean data is written and read with all-zero, all-one, alternating and top-bit-only patterns. These show that the data-to-position mapping and the check bits agree for every bit. A flip of a data bit is compared with a flip of a check bit: both must report a single-bit error, but only the data-bit case needs the data repaired. A two-bit flip shows that the uncorrectable case returns raw data and does not miscorrect it. A word corrupted while protection is off is read twice, once with protection off and once with it on. This separates pass-through from correction of the same stored codeword.

// File: rtl/ecc_buf_pkg.sv
package ecc_buf_pkg;

  localparam int REG_W = 3;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_MASK = 2'd2;

  typedef enum logic [1:0] {
    INJ_NONE   = 2'b00,
    INJ_DATA1  = 2'b01,
    INJ_CHECK1 = 2'b10,
    INJ_DATA2  = 2'b11
  } inj_mode_e;

  // smallest p with 2**p >= dw + p + 1
  function automatic int hamming_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p = p + 1;
    return p;
  endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc #(
  parameter int DW = 64,
  parameter int PW = 7
) (
  input  logic [DW-1:0] d,
  output logic [PW-1:0] chk
);
  localparam int HN = DW + PW;

  always_comb begin
    int k;
    k   = 0;
    chk = '0;
    for (int pos = 1; pos <= HN; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int j = 0; j < PW; j++) begin
          if (((pos >> j) & 1) == 1) chk[j] = chk[j] ^ d[k];
        end
        k = k + 1;
      end
    end
  end
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec #(
  parameter int DW = 64,
  parameter int PW = 7
) (
  input  logic          en,
  input  logic [DW-1:0] raw_d,
  input  logic [PW-1:0] raw_c,
  input  logic          raw_p,
  output logic [DW-1:0] q,
  output logic          sbe,
  output logic          dbe
);
  localparam int HN = DW + PW;

  logic [PW-1:0] re_c;
  logic [PW-1:0] syn;
  logic          odd;

  ecc_enc #(.DW(DW), .PW(PW)) u_reenc (.d(raw_d), .chk(re_c));

  assign syn = raw_c ^ re_c;
  assign odd = ^{raw_p, raw_c, raw_d};

  always_comb begin
    int k;
    k   = 0;
    q   = raw_d;
    sbe = 1'b0;
    dbe = 1'b0;
    if (en) begin
      if (odd) begin
        sbe = 1'b1;
        for (int pos = 1; pos <= HN; pos++) begin
          if ((pos & (pos - 1)) != 0) begin
            if (pos == int'(syn)) q[k] = ~q[k];
            k = k + 1;
          end
        end
      end else if (syn != '0) begin
        dbe = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ecc_csr.sv
module ecc_csr
  import ecc_buf_pkg::*;
(
  input  logic             clk,
  input  logic             srst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             sbe_evt,
  input  logic             dbe_evt,
  output logic             ecc_on,
  output inj_mode_e        inj,
  output logic [1:0]       stat,
  output logic             irq
);
  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic [1:0]       stat_q, stat_d;
  logic [1:0]       mask_q, mask_d;
  logic [REG_W-1:0] rdata_q, rdata_d;

  always_comb begin
    ctrl_d  = ctrl_q;
    mask_d  = mask_q;
    stat_d  = stat_q;
    rdata_d = rdata_q;
    if (wr && addr == ADDR_CTRL) ctrl_d = wdata;
    if (wr && addr == ADDR_MASK) mask_d = wdata[1:0];
    if (wr && addr == ADDR_STAT) stat_d = stat_q & ~wdata[1:0];
    // a new event wins over a clear in the same cycle
    stat_d = stat_d | {dbe_evt, sbe_evt};
    if (rd) begin
      case (addr)
        ADDR_CTRL: rdata_d = ctrl_q;
        ADDR_STAT: rdata_d = {1'b0, stat_q};
        ADDR_MASK: rdata_d = {1'b0, mask_q};
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q  <= 3'b001;
      stat_q  <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      stat_q  <= stat_d;
      mask_q  <= mask_d;
      rdata_q <= rdata_d;
    end
  end

  assign ecc_on = ctrl_q[0];
  assign inj    = inj_mode_e'(ctrl_q[2:1]);
  assign stat   = stat_q;
  assign rdata  = rdata_q;
  assign irq    = |(stat_q & mask_q);
endmodule

// File: rtl/ecc_buf.sv
module ecc_buf
  import ecc_buf_pkg::*;
#(
  parameter  int DW    = 64,
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             rd_sbe,
  output logic             rd_dbe,
  input  logic             csr_wr,
  input  logic             csr_rd,
  input  logic [1:0]       csr_addr,
  input  logic [REG_W-1:0] csr_wdata,
  output logic [REG_W-1:0] csr_rdata,
  output logic             irq
);
  localparam int PW = hamming_bits(DW);
  localparam int CW = DW + PW + 1;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      srst_n   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      srst_n   <= rst_meta;
    end
  end

  logic      ctrl_on_w;
  inj_mode_e inj_w;
  logic [1:0] stat_w;

  ecc_csr u_csr (
    .clk(clk), .srst_n(srst_n),
    .wr(csr_wr), .rd(csr_rd), .addr(csr_addr), .wdata(csr_wdata), .rdata(csr_rdata),
    .sbe_evt(rd_sbe), .dbe_evt(rd_dbe),
    .ecc_on(ctrl_on_w), .inj(inj_w), .stat(stat_w), .irq(irq)
  );

  // write path: encode and apply injection pattern
  logic [PW-1:0] enc_c;
  logic [CW-1:0] wr_word;
  logic [CW-1:0] inj_vec;

  ecc_enc #(.DW(DW), .PW(PW)) u_enc (.d(wr_data), .chk(enc_c));

  always_comb begin
    inj_vec = '0;
    case (inj_w)
      INJ_DATA1:  inj_vec[0]  = 1'b1;
      INJ_CHECK1: inj_vec[DW] = 1'b1;
      INJ_DATA2:  inj_vec[1:0] = 2'b11;
      default:    inj_vec = '0;
    endcase
    wr_word = {^{enc_c, wr_data}, enc_c, wr_data} ^ inj_vec;
  end

  logic [CW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
  end

  // read path: one register stage then decode
  logic [CW-1:0] rd_word_q;
  logic          rd_valid_q, rd_valid_d;

  assign rd_valid_d = rd_en;

  always_ff @(posedge clk) begin
    if (rd_en) rd_word_q <= mem[rd_addr];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rd_valid_q <= 1'b0;
    else         rd_valid_q <= rd_valid_d;
  end

  ecc_dec #(.DW(DW), .PW(PW)) u_dec (
    .en(ctrl_on_w & rd_valid_q),
    .raw_d(rd_word_q[DW-1:0]),
    .raw_c(rd_word_q[DW+PW-1:DW]),
    .raw_p(rd_word_q[CW-1]),
    .q(rd_data), .sbe(rd_sbe), .dbe(rd_dbe)
  );

  assign rd_valid = rd_valid_q;
endmodule

// File: rtl/ecc_buf_chk.sv
module ecc_buf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       rd_valid,
  input logic       rd_sbe,
  input logic       rd_dbe,
  input logic       irq,
  input logic       csr_wr,
  input logic [1:0] csr_addr,
  input logic [1:0] wmask,
  input logic [1:0] stat,
  input logic       ecc_on
);
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);  // R10

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_sbe && rd_dbe));  // R5

  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (!rd_sbe && !rd_dbe));  // R10

  AST_OFF_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !ecc_on |-> (!rd_sbe && !rd_dbe));  // R9

  AST_SBE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[0]) |-> $past(csr_wr && csr_addr == 2'd1 && wmask[0]));  // R6

  AST_DBE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[1]) |-> $past(csr_wr && csr_addr == 2'd1 && wmask[1]));  // R7

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(rd_sbe || rd_dbe || csr_wr));  // R8
endmodule

bind ecc_buf ecc_buf_chk u_chk (
  .clk(clk), .rst_n(srst_n), .rd_en(rd_en), .rd_valid(rd_valid),
  .rd_sbe(rd_sbe), .rd_dbe(rd_dbe), .irq(irq), .csr_wr(csr_wr),
  .csr_addr(csr_addr), .wmask(csr_wdata[1:0]), .stat(stat_w), .ecc_on(ctrl_on_w)
);

// File: tb/sim_ecc_buf.sv
`timescale 1ns/1ps
module sim_ecc_buf;
  localparam int DW = 64;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en, csr_wr, csr_rd;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;
  logic          rd_valid, rd_sbe, rd_dbe, irq;
  logic [1:0]    csr_addr;
  logic [2:0]    csr_wdata, csr_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ecc_buf u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_sbe(rd_sbe), .rd_dbe(rd_dbe), .csr_wr(csr_wr), .csr_rd(csr_rd),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [1:0] a, input logic [2:0] v);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = v;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic csr_read(input logic [1:0] a, output logic [2:0] v);
    @(negedge clk);
    csr_rd = 1'b1; csr_addr = a;
    @(negedge clk);
    csr_rd = 1'b0;
    v = csr_rdata;
  endtask

  task automatic buf_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic buf_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                          output logic s, output logic db);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; s = rd_sbe; db = rd_dbe;
    @(negedge clk);  // let status register update
  endtask

  task automatic t_reset;
    logic [2:0] v;
    check("R1 rd_valid", {63'b0, rd_valid}, 64'd0);
    check("R1 irq", {63'b0, irq}, 64'd0);
    csr_read(2'd0, v); check("R1 ctrl", {61'b0, v}, 64'd1);
    csr_read(2'd1, v); check("R1 status", {61'b0, v}, 64'd0);
    csr_read(2'd2, v); check("R1 mask", {61'b0, v}, 64'd0);
  endtask

  task automatic t_clean;
    logic [DW-1:0] pat [4];
    logic [DW-1:0] d; logic s, db;
    pat[0] = '0; pat[1] = '1; pat[2] = 64'hAAAA_5555_AAAA_5555; pat[3] = 64'h8000_0000_0000_0000;
    for (int i = 0; i < 4; i++) buf_write(AW'(i), pat[i]);
    for (int i = 0; i < 4; i++) begin
      buf_read(AW'(i), d, s, db);
      check("R2 data", d, pat[i]);
      check("R2 flags", {62'b0, s, db}, 64'd0);
    end
  endtask

  task automatic t_latency;
    @(negedge clk);
    rd_en = 1'b1; rd_addr = '0;
    @(negedge clk);
    rd_en = 1'b0;
    check("R10 valid after strobe", {63'b0, rd_valid}, 64'd1);
    @(negedge clk);
    check("R10 valid one cycle", {63'b0, rd_valid}, 64'd0);
  endtask

  task automatic t_single_data;
    logic [DW-1:0] d; logic s, db; logic [2:0] v;
    csr_write(2'd0, 3'b011);
    buf_write(4'd5, 64'h0123_4567_89AB_CDEF);
    csr_write(2'd0, 3'b001);
    buf_read(4'd5, d, s, db);
    check("R3 corrected data", d, 64'h0123_4567_89AB_CDEF);
    check("R3 flags", {62'b0, s, db}, 64'd2);
    csr_read(2'd1, v); check("R6 status sbe set", {61'b0, v}, 64'd1);
    buf_read(4'd0, d, s, db);
    csr_read(2'd1, v); check("R6 status sticky", {61'b0, v}, 64'd1);
  endtask

  task automatic t_double;
    logic [DW-1:0] d; logic s, db; logic [2:0] v;
    csr_write(2'd0, 3'b111);
    buf_write(4'd6, 64'hDEAD_BEEF_0000_FFFF);
    csr_write(2'd0, 3'b001);
    buf_read(4'd6, d, s, db);
    check("R5 raw data", d, 64'hDEAD_BEEF_0000_FFFF ^ 64'd3);
    check("R5 flags", {62'b0, s, db}, 64'd1);
    csr_read(2'd1, v); check("R6 both status bits", {61'b0, v}, 64'd3);
  endtask

  task automatic t_w1c;
    logic [2:0] v;
    csr_write(2'd1, 3'b010);
    csr_read(2'd1, v); check("R7 clear dbe only", {61'b0, v}, 64'd1);
    csr_write(2'd1, 3'b001);
    csr_read(2'd1, v); check("R7 clear sbe", {61'b0, v}, 64'd0);
  endtask

  task automatic t_check_flip_irq;
    logic [DW-1:0] d; logic s, db;
    csr_write(2'd0, 3'b101);
    buf_write(4'd8, 64'h5A5A_0F0F_F0F0_A5A5);
    csr_write(2'd0, 3'b001);
    buf_read(4'd8, d, s, db);
    check("R4 data unchanged", d, 64'h5A5A_0F0F_F0F0_A5A5);
    check("R4 flags", {62'b0, s, db}, 64'd2);
    check("R8 irq masked", {63'b0, irq}, 64'd0);
    csr_write(2'd2, 3'b010);
    check("R8 irq other mask", {63'b0, irq}, 64'd0);
    csr_write(2'd2, 3'b001);
    check("R8 irq enabled", {63'b0, irq}, 64'd1);
    csr_write(2'd1, 3'b001);
    check("R8 irq after clear", {63'b0, irq}, 64'd0);
    csr_write(2'd2, 3'b000);
  endtask

  task automatic t_off;
    logic [DW-1:0] d; logic s, db; logic [2:0] v;
    csr_write(2'd0, 3'b010);
    buf_write(4'd7, 64'hFEDC_BA98_7654_3210);
    buf_read(4'd7, d, s, db);
    check("R9 raw pass-through", d, 64'hFEDC_BA98_7654_3210 ^ 64'd1);
    check("R9 no flags", {62'b0, s, db}, 64'd0);
    csr_read(2'd1, v); check("R9 status untouched", {61'b0, v}, 64'd0);
    csr_write(2'd0, 3'b001);
    buf_read(4'd7, d, s, db);
    check("R9 corrected once on", d, 64'hFEDC_BA98_7654_3210);
    check("R9 sbe once on", {62'b0, s, db}, 64'd2);
    csr_write(2'd1, 3'b011);
  endtask

  initial begin
    rst_n = 1'b0;
    wr_en = 0; rd_en = 0; csr_wr = 0; csr_rd = 0;
    wr_addr = '0; rd_addr = '0; wr_data = '0; csr_addr = '0; csr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_clean();
    t_latency();
    t_single_data();
    t_double();
    t_w1c();
    t_check_flip_irq();
    t_off();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule